// File: doc/BRIEF.md
# Ternary Full Adder Cell

This block adds two ternary digits and a binary carry in one combinational step. Every trit travels on a 2-bit binary code: 00 is the value 0, 01 is the value 1 and 10 is the value 2. The block returns a sum trit in the same code and a carry trit that can only be 0 or 1. Chained by their carries, instances of the cell form a ripple adder of any trit width.

Inside, each operand code is turned into three one-hot level flags. The datapath forms the result twice: once for carry-in 0 and once for carry-in 1. The carry-in then picks one of the two. The carry-in 1 result reuses the carry-in 0 terms, shifted by one value, so nothing is computed twice. A half-adder input ties the effective carry-in to 0. The code 11 on either operand is illegal. It raises an error flag and forces a zero result.

Top module: `ternFullAdder`

## Requirements
- R1: With legal operands a, b (codes 00=0, 01=1, 10=2) and carry c in {0,1}, sumOut encodes (a+b+c) mod 3 in the same code.
- R2: carryOut encodes the value 1 (code 01) exactly when a+b+c is 3 or more, and the value 0 (code 00) otherwise.
- R3: carryOut is only ever 00 or 01, and sumOut is never 11.
- R4: With carry 0, the pairs (1,2) and (2,1) give sum 0 with carry 1, and (2,2) gives sum 1 with carry 1. Every other pair gives carry 0.
- R5: With carry 1, every pair with a+b of 2 or more gives carry 1. In particular (0,2) gives sum 0 with carry 1, and (2,2) gives sum 2 with carry 1.
- R6: While halfMode is 1, carryIn has no effect, and the outputs equal those for carry 0.
- R7: If either operand is 11, illegalIn is 1, sumOut is 00 and carryOut is 00, whatever the other inputs are.
- R8: With both operands legal, illegalIn is 0.
- R9: The outputs follow the inputs with no clock and no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 2 | First operand trit code |
| opB | input | 2 | Second operand trit code |
| carryIn | input | 1 | Binary carry in (0 or 1) |
| halfMode | input | 1 | 1 ties the effective carry-in to 0 |
| sumOut | output | 2 | Sum trit code |
| carryOut | output | 2 | Carry trit code, 00 or 01 |
| illegalIn | output | 1 | 1 when an operand carries code 11 |

## Verification
The bench drives all 18 legal operand and carry combinations, in both values of halfMode. It adds random vectors and directed cases for the carry-producing pairs. A design that swapped the shifted terms of the carry-in 1 path would give wrong sums only when carry-in is 1. The (0,2) and (2,2) cases catch this. A design that took the carry-in 1 carry from the carry-in 0 carry alone would miss the carry for a+b = 2. A design that let carryIn through while halfMode is set fails R6. Each operand is also set to 11 in turn, with the other inputs varied. A decoder that read 11 as 2, or a datapath that was not cleared, would then show a non-zero sum, a non-zero carry or a missing error flag.

// File: rtl/ternPkg.sv
package ternPkg;
  localparam int TRIT_W  = 2;
  localparam int LEVELS  = 3;
  localparam int NUM_OPS = 2;

  typedef logic [TRIT_W-1:0] tritCode;

  localparam tritCode TRIT_ZERO = 2'b00;
  localparam tritCode TRIT_ONE  = 2'b01;
  localparam tritCode TRIT_TWO  = 2'b10;

  // bit index equals the level value
  typedef logic [LEVELS-1:0] levelFlags;

  typedef struct packed {
    logic selCin1;
    logic forceZero;
    logic errFlag;
  } ctrlStrobes;
endpackage

// File: rtl/tritLevelDetect.sv
module tritLevelDetect
  import ternPkg::*;
(
  input  tritCode   code,
  output levelFlags flags
);
  always_comb begin
    flags    = '0;
    flags[0] = (code == TRIT_ZERO);
    flags[1] = (code == TRIT_ONE);
    flags[2] = (code == TRIT_TWO);
  end

  // R7
  always_comb begin
    flags_onehot_chk: assert ($onehot0(flags) && ((code == 2'b11) == (flags == '0)));
  end
endmodule

// File: rtl/ternAddCtrl.sv
module ternAddCtrl
  import ternPkg::*;
(
  input  logic       carryIn,
  input  logic       halfMode,
  input  levelFlags  flagsA,
  input  levelFlags  flagsB,
  output ctrlStrobes strobes
);
  logic badOperand;

  always_comb begin
    badOperand        = ~|flagsA | ~|flagsB;
    strobes.selCin1   = carryIn & ~halfMode & ~badOperand;
    strobes.forceZero = badOperand;
    strobes.errFlag   = badOperand;
  end

  // R6
  always_comb begin
    half_sel_chk: assert (!(halfMode && strobes.selCin1));
  end
endmodule

// File: rtl/ternAddDatapath.sv
module ternAddDatapath
  import ternPkg::*;
(
  input  levelFlags  flagsA,
  input  levelFlags  flagsB,
  input  ctrlStrobes strobes,
  output tritCode    sumCode,
  output tritCode    carryCode
);
  levelFlags sumLo, sumHi, sumSel;
  logic      carryLo, carryHi, carrySel;

  // carry-in 0 partial result, built from every pair of levels
  always_comb begin
    sumLo   = '0;
    carryLo = 1'b0;
    for (int i = 0; i < LEVELS; i++) begin
      for (int j = 0; j < LEVELS; j++) begin
        sumLo[(i + j) % LEVELS] = sumLo[(i + j) % LEVELS] | (flagsA[i] & flagsB[j]);
        if (i + j >= LEVELS) carryLo = carryLo | (flagsA[i] & flagsB[j]);
      end
    end
  end

  // carry-in 1 partial result reuses the carry-in 0 terms rotated by one
  always_comb begin
    for (int v = 0; v < LEVELS; v++) sumHi[(v + 1) % LEVELS] = sumLo[v];
    carryHi = carryLo | sumLo[LEVELS-1];
  end

  always_comb begin
    sumSel    = strobes.selCin1 ? sumHi : sumLo;
    carrySel  = strobes.selCin1 ? carryHi : carryLo;
    sumCode   = strobes.forceZero ? TRIT_ZERO : {sumSel[2], sumSel[1]};
    carryCode = (carrySel && !strobes.forceZero) ? TRIT_ONE : TRIT_ZERO;
  end

  // R7
  always_comb begin
    force_zero_chk: assert (!strobes.forceZero || (sumCode == TRIT_ZERO && carryCode == TRIT_ZERO));
  end
  // R1
  always_comb begin
    sum_onehot_chk: assert (strobes.forceZero || $onehot(sumSel));
  end
  // R3
  always_comb begin
    code_range_chk: assert (sumCode != 2'b11 && carryCode[1] == 1'b0);
  end
endmodule

// File: rtl/ternFullAdder.sv
module ternFullAdder
  import ternPkg::*;
(
  input  logic [1:0] opA,
  input  logic [1:0] opB,
  input  logic       carryIn,
  input  logic       halfMode,
  output logic [1:0] sumOut,
  output logic [1:0] carryOut,
  output logic       illegalIn
);
  tritCode    operand [NUM_OPS];
  levelFlags  flags   [NUM_OPS];
  ctrlStrobes strobes;

  assign operand[0] = opA;
  assign operand[1] = opB;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_detect
    tritLevelDetect i_detect (.code(operand[k]), .flags(flags[k]));
  end

  ternAddCtrl i_ctrl (
    .carryIn (carryIn),
    .halfMode(halfMode),
    .flagsA  (flags[0]),
    .flagsB  (flags[1]),
    .strobes (strobes)
  );

  ternAddDatapath i_dp (
    .flagsA   (flags[0]),
    .flagsB   (flags[1]),
    .strobes  (strobes),
    .sumCode  (sumOut),
    .carryCode(carryOut)
  );

  assign illegalIn = strobes.errFlag;
endmodule

// File: tb/test_ternFullAdder.sv
module test_ternFullAdder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] opA = 2'b00, opB = 2'b00;
  logic carryIn = 1'b0, halfMode = 1'b0;
  logic [1:0] sumOut, carryOut;
  logic illegalIn;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ternFullAdder i_ternFullAdder (
    .opA(opA), .opB(opB), .carryIn(carryIn), .halfMode(halfMode),
    .sumOut(sumOut), .carryOut(carryOut), .illegalIn(illegalIn)
  );

  function automatic logic [4:0] expOut(input logic [1:0] a, input logic [1:0] b,
                                        input logic c, input logic h);
    int t;
    if (a == 2'b11 || b == 2'b11) return 5'b1_00_00;
    t = int'(a) + int'(b) + ((c && !h) ? 1 : 0);
    return {1'b0, (t >= 3) ? 2'b01 : 2'b00, 2'(t % 3)};
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%b b=%b cin=%b half=%b got err/carry/sum=%b expected %b",
               req, opA, opB, carryIn, halfMode, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] a, input logic [1:0] b, input logic c,
                       input logic h, input string req);
    @(negedge clk);
    opA = a; opB = b; carryIn = c; halfMode = h;
    #1;
    check(req, {illegalIn, carryOut, sumOut}, expOut(a, b, c, h));
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] prevOut;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #1;
    check("R9 reset-state zero inputs", {illegalIn, carryOut, sumOut}, 5'b0_00_00);

    // R1 R2 R8: all 18 legal combinations, halfMode off
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          apply(2'(a), 2'(b), 1'(c), 1'b0, "R1/R2/R8 exhaustive");

    // R4 carry-in 0 carrying pairs
    apply(2'd1, 2'd2, 1'b0, 1'b0, "R4 (1,2)");
    check("R4 (1,2) sum0 carry1", {illegalIn, carryOut, sumOut}, 5'b0_01_00);
    apply(2'd2, 2'd1, 1'b0, 1'b0, "R4 (2,1)");
    apply(2'd2, 2'd2, 1'b0, 1'b0, "R4 (2,2)");
    check("R4 (2,2) sum1 carry1", {illegalIn, carryOut, sumOut}, 5'b0_01_01);

    // R5 carry-in 1 corners
    apply(2'd0, 2'd2, 1'b1, 1'b0, "R5 (0,2)");
    check("R5 (0,2) sum0 carry1", {illegalIn, carryOut, sumOut}, 5'b0_01_00);
    apply(2'd1, 2'd1, 1'b1, 1'b0, "R5 (1,1)");
    apply(2'd2, 2'd2, 1'b1, 1'b0, "R5 (2,2)");
    check("R5 (2,2) sum2 carry1", {illegalIn, carryOut, sumOut}, 5'b0_01_10);

    // R6 halfMode: carryIn ignored
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++) begin
        apply(2'(a), 2'(b), 1'b1, 1'b1, "R6 half cin1");
        prevOut = {illegalIn, carryOut, sumOut};
        apply(2'(a), 2'(b), 1'b0, 1'b1, "R6 half cin0");
        check("R6 cin no effect", {illegalIn, carryOut, sumOut}, prevOut);
      end

    // R7 illegal code on each operand
    for (int o = 0; o < 4; o++) begin
      apply(2'b11, 2'(o), 1'b1, 1'b0, "R7 opA illegal");
      apply(2'(o), 2'b11, 1'b1, 1'b0, "R7 opB illegal");
      apply(2'b11, 2'(o), 1'b0, 1'b1, "R7 opA illegal half");
    end

    // R3 R9 random mix
    for (int n = 0; n < 300; n++) begin
      logic [1:0] ra, rb;
      ra = 2'($urandom % 4);
      rb = 2'($urandom % 4);
      apply(ra, rb, 1'($urandom % 2), 1'($urandom % 2), "R3/R9 random");
      checks++;
      if (sumOut == 2'b11 || carryOut[1]) begin
        fails++;
        $display("FAIL R3 code range sum=%b carry=%b expected legal codes", sumOut, carryOut);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule